// File: doc/BRIEF.md
# Strobe-Framed Serial Register Slave

This block is a 256-entry byte register file that an external master drives over a narrow serial link. The master sends two bits on each rising edge of its serial clock. A word is nine clocks long. It holds a data byte and an address byte, which take four clocks each, and then a two-bit command on the last clock. The master raises a command strobe on that last clock only. The strobe is the only thing that marks the end of a word. Clocks that arrive with the strobe low before a word only push stale bits through the input shifter, and the following word overwrites those bits.

A write command stores the data byte at the address. A read command sends the addressed byte out on a single output line, most significant bit first. The first bit is driven on the falling edge that follows the strobed rising edge. To meet that half-cycle deadline, the address bits in the shifter are applied to the register read mux on every clock, so the read data is already selected when the strobe arrives. The first output bit is taken straight from that mux. The remaining bits come from a shift register that was loaded with the same byte. A new word can start on the clock right after a read strobe, while the byte is still being shifted out.

Top module: `strobe_reg_slave`

## Requirements
- R1: While rst_ni is low, all registers are cleared to zero, the input shifter is cleared and dout_o is low. A read of any address before its first write returns 0x00.
- R2: On each rising edge with the strobe low, din_i[1] is shifted in ahead of din_i[0]. The last eight such clocks before the strobe carry the data byte (MSB pair first) and then the address byte (MSB pair first). On the strobe clock, din_i carries the command, and the shifter holds its contents.
- R3: Command 2'b10 on the strobe clock writes the data byte to the address. Later reads of that address return the new byte.
- R4: Command 2'b01 on the strobe clock drives bit 7 of the addressed byte on dout_o from the next falling edge.
- R5: After a read strobe, bits 6 down to 0 follow on the next seven falling edges, one per clock. From the ninth falling edge onward, dout_o is low until the next read strobe.
- R6: Any number of clocks with the strobe low and arbitrary din_i, placed before a word's nine clocks, does not change the outcome of that word.
- R7: Commands 2'b00 and 2'b11 change no register. They leave dout_o idle when no read is in progress, and they do not disturb a read that is being shifted out.
- R8: A new word sent on the clocks immediately after a read strobe does not alter the byte being shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk_i | input | 1 | Serial clock from the master; inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 2 | Serial input pair; bit 1 is the earlier bit |
| strobe_i | input | 1 | High only on the last clock of a word, which carries the command |
| dout_o | output | 1 | Serial read data, changes on falling edges, low when idle |

## Verification
Random writes fill the register file from a bench model. Random reads are then made under several kinds of traffic: back-to-back reads, a read followed at once by a write or a no-op word, and words preceded by runs of stray clocks with random input bits. The back-to-back cases show that the output shift register is independent of the input shifter, which keeps moving. The stray-clock cases show that framing comes only from the strobe. Directed corner cases cover the lowest and highest addresses, a read of the address that was just written, reads of untouched registers after reset, and both no-op codes sent in the middle of an active read.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    CMD_NOP_LO = 2'b00,
    CMD_READ   = 2'b01,
    CMD_WRITE  = 2'b10,
    CMD_NOP_HI = 2'b11
  } srs_cmd_e;
endpackage

// File: rtl/srs_shifter.sv
module srs_shifter #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int IN_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IN_W-1:0]   din_i,
  input  logic              strobe_i,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W+ADDR_W-1:0] word_o
);
  localparam int SH_W = DATA_W + ADDR_W;

  logic [SH_W-1:0] sh_q;

  // strobe clock carries the command; payload is held for decode and serializer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '0;
    else if (!strobe_i) sh_q <= {sh_q[SH_W-IN_W-1:0], din_i};
  end

  assign data_o = sh_q[SH_W-1:ADDR_W];
  assign addr_o = sh_q[ADDR_W-1:0];
  assign word_o = sh_q;
endmodule

// File: rtl/srs_regfile.sv
module srs_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         mem_q[g] <= '0;
      else if (we_i && (addr_i == ADDR_W'(g))) mem_q[g] <= wdata_i;
    end
  end

  // read mux follows the shifter continuously: prefetch before strobe
  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/srs_serializer.sv
module srs_serializer #(
  parameter int DATA_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [DATA_W-1:0]         byte_i,
  output logic                      dout_o,
  output logic                      active_o,
  output logic [$clog2(DATA_W)-1:0] cnt_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic              sel_mux;
  logic              dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      shreg_q  <= byte_i;
    end else if (active_q) begin
      shreg_q <= shreg_q << 1;
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // first bit bypasses the shift register: half-cycle path from the mux
  assign sel_mux = active_q && (cnt_q == '0);

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dout_q <= 1'b0;
    else if (!active_q) dout_q <= 1'b0;
    else if (sel_mux)  dout_q <= byte_i[DATA_W-1];
    else               dout_q <= shreg_q[DATA_W-1];
  end

  assign dout_o   = dout_q;
  assign active_o = active_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int IN_W   = 2
) (
  input  logic            sclk_i,
  input  logic            rst_ni,
  input  logic [IN_W-1:0] din_i,
  input  logic            strobe_i,
  output logic            dout_o
);
  import srs_pkg::*;

  localparam int SH_W  = DATA_W + ADDR_W;
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] wdata;
  logic [ADDR_W-1:0] addr;
  logic [SH_W-1:0]   sh_word;
  logic [DATA_W-1:0] rd_byte;
  logic              ser_active;
  logic [CNT_W-1:0]  ser_cnt;
  srs_cmd_e          cmd;
  logic              do_read;
  logic              do_write;

  assign cmd      = srs_cmd_e'(din_i[1:0]);
  assign do_read  = strobe_i && (cmd == CMD_READ);
  assign do_write = strobe_i && (cmd == CMD_WRITE);

  srs_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IN_W(IN_W)) i_shifter (
    .clk_i   (sclk_i),
    .rst_ni  (rst_ni),
    .din_i   (din_i),
    .strobe_i(strobe_i),
    .data_o  (wdata),
    .addr_o  (addr),
    .word_o  (sh_word)
  );

  srs_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regfile (
    .clk_i  (sclk_i),
    .rst_ni (rst_ni),
    .we_i   (do_write),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rd_byte)
  );

  srs_serializer #(.DATA_W(DATA_W)) i_serializer (
    .clk_i   (sclk_i),
    .rst_ni  (rst_ni),
    .load_i  (do_read),
    .byte_i  (rd_byte),
    .dout_o  (dout_o),
    .active_o(ser_active),
    .cnt_o   (ser_cnt)
  );
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int IN_W   = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [IN_W-1:0]           din_i,
  input logic                      strobe_i,
  input logic                      dout_i,
  input logic [DATA_W+ADDR_W-1:0]  sh_i,
  input logic [DATA_W-1:0]         rd_byte_i,
  input logic                      active_i,
  input logic [$clog2(DATA_W)-1:0] cnt_i
);
  localparam logic [$clog2(DATA_W)-1:0] LAST = ($clog2(DATA_W))'(DATA_W - 1);

  // R4
  first_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && din_i == 2'b01) |=> (dout_i == $past(rd_byte_i[DATA_W-1])));

  // R5
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !dout_i);

  // R5
  read_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cnt_i == LAST && !(strobe_i && din_i == 2'b01)) |=> !active_i);

  // R2
  hold_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> $stable(sh_i));

  // R2
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> (sh_i[IN_W-1:0] == $past(din_i)));

  // R7
  nop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && din_i[1] == din_i[0] && !active_i) |=> !active_i);
endmodule

bind strobe_reg_slave srs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IN_W(IN_W)) i_srs_chk (
  .clk_i    (sclk_i),
  .rst_ni   (rst_ni),
  .din_i    (din_i),
  .strobe_i (strobe_i),
  .dout_i   (dout_o),
  .sh_i     (sh_word),
  .rd_byte_i(rd_byte),
  .active_i (ser_active),
  .cnt_i    (ser_cnt)
);

// File: tb/test_strobe_reg_slave.sv
module test_strobe_reg_slave;
  logic       sclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] din = 2'b00;
  logic       strobe = 1'b0;
  logic       dout;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] mem [256];
  logic [7:0] exp_sh = '0;
  int         exp_left = 0;

  always #10 sclk = ~sclk; // 50 MHz

  strobe_reg_slave i_strobe_reg_slave (
    .sclk_i  (sclk),
    .rst_ni  (rst_n),
    .din_i   (din),
    .strobe_i(strobe),
    .dout_o  (dout)
  );

  function automatic string tag_for(int left);
    if (left == 8) return "R4";
    return "R5";
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dout actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one serial clock: sample output set at this falling edge, then drive inputs
  task automatic tick(logic [1:0] d, logic s);
    logic e;
    @(negedge sclk);
    #1;
    e = (exp_left > 0) ? exp_sh[7] : 1'b0;
    check(tag_for(exp_left), dout, e);
    if (exp_left > 0) begin
      exp_sh = exp_sh << 1;
      exp_left--;
    end
    din = d;
    strobe = s;
  endtask

  task automatic stray(int n);
    for (int i = 0; i < n; i++) tick(2'($urandom), 1'b0);
  endtask

  // R2 framing: 4 data clocks, 4 address clocks (MSB pair first), strobe clock
  task automatic send_word(logic [7:0] data, logic [7:0] addr, logic [1:0] cmd);
    for (int i = 0; i < 4; i++) tick(data[7-2*i -: 2], 1'b0);
    for (int i = 0; i < 4; i++) tick(addr[7-2*i -: 2], 1'b0);
    tick(cmd, 1'b1);
    if (cmd == 2'b10) mem[addr] = data;
    else if (cmd == 2'b01) begin
      exp_sh = mem[addr];
      exp_left = 8;
    end
  endtask

  initial begin
    void'($urandom(32'h1badcafe));
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(posedge sclk);
    #3;
    check("R1", dout, 1'b0);
    @(negedge sclk);
    #1;
    rst_n = 1'b1;

    // R1: untouched registers read as zero
    send_word(8'h3c, 8'h00, 2'b01);
    send_word(8'h00, 8'hff, 2'b01);
    send_word(8'h00, 8'h7e, 2'b00); // R7 nop during active read
    stray(2);

    // R3 directed corners
    send_word(8'ha5, 8'h00, 2'b10);
    send_word(8'h5a, 8'hff, 2'b10);
    send_word(8'h00, 8'hff, 2'b01); // read just-written address
    send_word(8'hff, 8'h00, 2'b01); // R8 back-to-back read
    send_word(8'hc3, 8'h10, 2'b10); // R8 write during shift-out
    send_word(8'h00, 8'h10, 2'b01);
    send_word(8'h99, 8'h10, 2'b11); // R7 nop code 11, must not write
    stray(9);
    send_word(8'h00, 8'h10, 2'b01);
    stray(9);

    // random fill with stray clocks (R6)
    for (int i = 0; i < 60; i++) begin
      stray($urandom_range(0, 5));
      send_word(8'($urandom), 8'($urandom), 2'b10);
    end

    // random mixed traffic
    for (int i = 0; i < 200; i++) begin
      int c;
      if ($urandom_range(0, 2) == 0) stray($urandom_range(1, 6));
      c = $urandom_range(0, 9);
      if (c < 5)      send_word(8'($urandom), 8'($urandom), 2'b01);
      else if (c < 8) send_word(8'($urandom), 8'($urandom), 2'b10);
      else if (c < 9) send_word(8'($urandom), 8'($urandom), 2'b00);
      else            send_word(8'($urandom), 8'($urandom), 2'b11);
    end

    // read back every register (R3, R7)
    for (int a = 0; a < 256; a++) send_word(8'($urandom), 8'(a), 2'b01);
    stray(10);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule